// File: doc/BRIEF.md
# Crystal-Clocked Timestamp and Timer Pulse Source

This block runs on the crystal reference clock and keeps a wide free-running count of its cycles. Three coarse timestamps come from that count, each shifted right by its own programmable amount: one for logging, one for tagging and one for address-translation entries. The logging timestamp can also come from a slower legacy millisecond counter.

The same reference clock drives a two-level timer chain. A programmable divider turns the reference into a common tick, 100 kHz when the ratio is 192 at 19.2 MHz. Three pulse generators count common ticks, and each emits a one-cycle strobe once per selectable period. Timers elsewhere on the chip use these strobes. Software sets the configuration through a small word-wide write port, and a combinational read port returns the stored settings. To change the divider rate, software clears the divider register, writes the new ratio with the enable bit low, and then sets the enable bit.

Top module: `xtb_timebase`

## Requirements
- R1: `raw_ts` is 0 while `rst` is high and rises by exactly one on every clock edge after that. A configuration write never disturbs it.
- R2: The timestamp register sits at address 0. Its tag shift field is bits [13:8] and its translation shift field is bits [21:16]. `tag_ts` equals `raw_ts` shifted right by the tag field, and `xlat_ts` equals `raw_ts` shifted right by the translation field. A shift of 0 passes `raw_ts` through unchanged.
- R3: Address 0 also holds the logging controls. When bit 24 is 1, `log_ts` equals `raw_ts` shifted right by bits [5:0]. When bit 24 is 0, `log_ts` is the legacy count, which rises once every LEGACY_DIV cycles from reset and therefore equals `raw_ts / LEGACY_DIV`.
- R4: The divider register sits at address 2. Bits [15:0] hold the ratio minus one (V), and bit 31 is the enable. The write that enables the divider takes effect on one clock edge. Counting that edge as edge 0, `tick_o` is high for one cycle after edge V and then after every V+1 further edges.
- R5: While the divider enable is 0, `tick_o` and every bit of `pulse_o` stay low.
- R6: Any write to address 2 restarts the divider and all pulse generators from zero. If a tick or pulse is due in the cycle of that write, it still appears in that cycle. The next tick then follows V edges after the write edge.
- R7: The granularity register sits at address 1. Generator i uses bits [2i+1:2i]. The codes 0, 1, 2 and 3 select periods of 1, 10, 100 and 1000 common ticks. A generator's strobe coincides with the tick that completes its period, so with period P and ratio R the first strobe follows edge P*R-1.
- R8: After reset, address 0 reads 0x0118_0E0E (logging and tag shifts 14, translation shift 24, select 1). Address 1 reads 0x29 (100 µs, 1 ms, 1 ms). Address 2 reads 0xBF (ratio 192, divider disabled). Address 3 reads 0.
- R9: `cfg_rdata` returns the last written value of the register at `cfg_addr`, with unused bits read as 0. A write becomes visible after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Register address for writes and reads |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| raw_ts | output | TS_W | Free-running base count |
| log_ts | output | TS_W | Logging timestamp |
| tag_ts | output | TS_W | Tag timestamp |
| xlat_ts | output | TS_W | Translation timestamp |
| tick_o | output | 1 | Common timer tick |
| pulse_o | output | NUM_GEN | Pulse generator strobes |

## Verification
A divider register write can land in the same cycle as a tick, and as a pulse that is due. The bench enables the divider with a ratio of 2 and the fastest granularity, waits until a tick is visible, and writes a new ratio during that exact cycle. It judges two things: the tick and the pulse must still show in that cycle, and the next tick must arrive exactly V edges after the write edge. This confirms that the restart does not swallow an event that is already due, and that the old phase does not leak into the new count.

// File: rtl/xtb_pkg.sv
package xtb_pkg;

    typedef enum logic [1:0] {
        GRAN_X1    = 2'd0,
        GRAN_X10   = 2'd1,
        GRAN_X100  = 2'd2,
        GRAN_X1000 = 2'd3
    } gran_e;

    localparam int unsigned GEN_CNT_W = 10;

    localparam logic [1:0] ADDR_TS   = 2'd0;
    localparam logic [1:0] ADDR_GRAN = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;

    localparam int unsigned TAG_LSB = 8;
    localparam int unsigned XL_LSB  = 16;
    localparam int unsigned SEL_BIT = 24;
    localparam int unsigned EN_BIT  = 31;

    function automatic logic [GEN_CNT_W-1:0] gran_last(gran_e g);
        case (g)
            GRAN_X1:   return GEN_CNT_W'(0);
            GRAN_X10:  return GEN_CNT_W'(9);
            GRAN_X100: return GEN_CNT_W'(99);
            default:   return GEN_CNT_W'(999);
        endcase
    endfunction

endpackage

// File: rtl/xtb_divider.sv
module xtb_divider #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        tick = en && (st_q.cnt == div_val);
        st_d = st_q;
        if (restart || !en || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/xtb_pulsegen.sv
module xtb_pulsegen
    import xtb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  tick,
    input  gran_e gran,
    output logic  pulse
);
    typedef struct packed {
        logic [GEN_CNT_W-1:0] cnt;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic [GEN_CNT_W-1:0] last;

    always_comb begin
        last  = gran_last(gran);
        pulse = tick && (st_q.cnt >= last);
        st_d  = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = (st_q.cnt >= last) ? '0 : st_q.cnt + GEN_CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/xtb_legacy_ms.sv
module xtb_legacy_ms #(
    parameter int unsigned TS_W       = 56,
    parameter int unsigned LEGACY_DIV = 19200
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] ms_count
);
    localparam int unsigned PRE_W = (LEGACY_DIV > 1) ? $clog2(LEGACY_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(LEGACY_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [TS_W-1:0]  ms;
    } ms_st_t;

    ms_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pre == PRE_LAST) begin
            st_d.pre = '0;
            st_d.ms  = st_q.ms + TS_W'(1);
        end else begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end
        ms_count = st_q.ms;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/xtb_timebase.sv
module xtb_timebase
    import xtb_pkg::*;
#(
    parameter int unsigned TS_W       = 56,
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned NUM_GEN    = 3,
    parameter int unsigned LEGACY_DIV = 19200
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    output logic [TS_W-1:0]    raw_ts,
    output logic [TS_W-1:0]    log_ts,
    output logic [TS_W-1:0]    tag_ts,
    output logic [TS_W-1:0]    xlat_ts,
    output logic               tick_o,
    output logic [NUM_GEN-1:0] pulse_o
);
    localparam int unsigned SH_W = $clog2(TS_W);
    localparam logic [31:0] USED_MASK = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [TS_W-1:0]         raw;
        logic [SH_W-1:0]         log_sh;
        logic [SH_W-1:0]         tag_sh;
        logic [SH_W-1:0]         xl_sh;
        logic                    log_sel;
        logic [NUM_GEN-1:0][1:0] gran;
        logic [DIV_W-1:0]        div_val;
        logic                    div_en;
    } tb_st_t;

    tb_st_t st_d, st_q;
    logic            div_restart;
    logic            gen_restart;
    logic [TS_W-1:0] legacy_ms;
    logic            div_en_w;
    logic [DIV_W-1:0] div_val_w;
    logic            unused_wdata;

    assign unused_wdata = ^(cfg_wdata & ~USED_MASK);

    always_comb begin
        st_d        = st_q;
        st_d.raw    = st_q.raw + TS_W'(1);
        div_restart = 1'b0;
        if (cfg_we) begin
            case (cfg_addr)
                ADDR_TS: begin
                    st_d.log_sh  = cfg_wdata[0 +: SH_W];
                    st_d.tag_sh  = cfg_wdata[TAG_LSB +: SH_W];
                    st_d.xl_sh   = cfg_wdata[XL_LSB +: SH_W];
                    st_d.log_sel = cfg_wdata[SEL_BIT];
                end
                ADDR_GRAN: begin
                    for (int i = 0; i < NUM_GEN; i++) begin
                        st_d.gran[i] = cfg_wdata[2*i +: 2];
                    end
                end
                ADDR_DIV: begin
                    st_d.div_val = cfg_wdata[DIV_W-1:0];
                    st_d.div_en  = cfg_wdata[EN_BIT];
                    div_restart  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.log_sh  <= SH_W'(14);
            st_q.tag_sh  <= SH_W'(14);
            st_q.xl_sh   <= SH_W'(24);
            st_q.log_sel <= 1'b1;
            st_q.div_val <= DIV_W'(191);
            for (int i = 0; i < NUM_GEN; i++) begin
                st_q.gran[i] <= (i == 0) ? GRAN_X10 : GRAN_X100;
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            ADDR_TS: begin
                cfg_rdata[0 +: SH_W]       = st_q.log_sh;
                cfg_rdata[TAG_LSB +: SH_W] = st_q.tag_sh;
                cfg_rdata[XL_LSB +: SH_W]  = st_q.xl_sh;
                cfg_rdata[SEL_BIT]         = st_q.log_sel;
            end
            ADDR_GRAN: begin
                for (int i = 0; i < NUM_GEN; i++) begin
                    cfg_rdata[2*i +: 2] = st_q.gran[i];
                end
            end
            ADDR_DIV: begin
                cfg_rdata[DIV_W-1:0] = st_q.div_val;
                cfg_rdata[EN_BIT]    = st_q.div_en;
            end
            default: ;
        endcase
    end

    assign raw_ts  = st_q.raw;
    assign tag_ts  = st_q.raw >> st_q.tag_sh;
    assign xlat_ts = st_q.raw >> st_q.xl_sh;
    assign log_ts  = st_q.log_sel ? (st_q.raw >> st_q.log_sh) : legacy_ms;

    assign div_en_w    = st_q.div_en;
    assign div_val_w   = st_q.div_val;
    assign gen_restart = div_restart || !st_q.div_en;

    xtb_legacy_ms #(.TS_W(TS_W), .LEGACY_DIV(LEGACY_DIV)) legacy_i (
        .clk      (clk),
        .rst      (rst),
        .ms_count (legacy_ms)
    );

    xtb_divider #(.DIV_W(DIV_W)) div_i (
        .clk     (clk),
        .rst     (rst),
        .en      (st_q.div_en),
        .restart (div_restart),
        .div_val (st_q.div_val),
        .tick    (tick_o)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        xtb_pulsegen gen_i (
            .clk     (clk),
            .rst     (rst),
            .restart (gen_restart),
            .tick    (tick_o),
            .gran    (gran_e'(st_q.gran[g])),
            .pulse   (pulse_o[g])
        );
    end
endmodule

// File: rtl/xtb_checker.sv
module xtb_checker #(
    parameter int unsigned TS_W    = 56,
    parameter int unsigned DIV_W   = 16,
    parameter int unsigned NUM_GEN = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic [1:0]         cfg_addr,
    input logic [31:0]        cfg_wdata,
    input logic [TS_W-1:0]    raw_ts,
    input logic               tick_o,
    input logic [NUM_GEN-1:0] pulse_o,
    input logic               div_en_w,
    input logic [DIV_W-1:0]   div_val_w
);
    p_raw_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> raw_ts == $past(raw_ts) + TS_W'(1));

    p_quiet_off_r5: assert property (@(posedge clk) disable iff (rst)
        !div_en_w |-> (!tick_o && pulse_o == '0));

    p_pulse_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        (pulse_o != '0) |-> tick_o);

    p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_val_w != '0 && !cfg_we) |=> !tick_o);

    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 2'd2 && cfg_wdata[DIV_W-1:0] != '0) |=> !tick_o);
endmodule

bind xtb_timebase xtb_checker #(.TS_W(TS_W), .DIV_W(DIV_W), .NUM_GEN(NUM_GEN)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .raw_ts    (raw_ts),
    .tick_o    (tick_o),
    .pulse_o   (pulse_o),
    .div_en_w  (div_en_w),
    .div_val_w (div_val_w)
);

// File: tb/xtb_timebase_tb_top.sv
`timescale 1ns/1ps
module xtb_timebase_tb_top;
    localparam int unsigned TS_W = 56;
    localparam int unsigned NG   = 3;
    localparam int unsigned LDIV = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = 2'd0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [TS_W-1:0] raw_ts, log_ts, tag_ts, xlat_ts;
    logic          tick_o;
    logic [NG-1:0] pulse_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    xtb_timebase #(.TS_W(TS_W), .DIV_W(16), .NUM_GEN(NG), .LEGACY_DIV(LDIV)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .raw_ts(raw_ts),
        .log_ts(log_ts), .tag_ts(tag_ts), .xlat_ts(xlat_ts),
        .tick_o(tick_o), .pulse_o(pulse_o)
    );

    task automatic chk(input bit ok, input string req,
                       input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        @(negedge clk);
        chk(raw_ts == 0, "R1 reset raw", raw_ts, 0);
        rst = 1'b0;
        rd(2'd0, d); chk(d == 32'h0118_0E0E, "R8 ts reg", d, 32'h0118_0E0E);
        rd(2'd1, d); chk(d == 32'h29, "R8 gran reg", d, 32'h29);
        rd(2'd2, d); chk(d == 32'hBF, "R8 div reg", d, 32'hBF);
        rd(2'd3, d); chk(d == 0, "R8 addr3", d, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(!tick_o && pulse_o == 0, "R5 idle after reset", {tick_o, pulse_o}, 0);
        end
    endtask

    task automatic t_raw;
        longint unsigned prev;
        for (int i = 0; i < 8; i++) begin
            prev = raw_ts;
            @(negedge clk);
            chk(raw_ts == prev + 1, "R1 step", raw_ts, prev + 1);
        end
        prev = raw_ts;
        wr(2'd2, 32'h0000_0005);
        chk(raw_ts == prev + 2, "R1 across write", raw_ts, prev + 2);
    endtask

    task automatic t_shift;
        logic [31:0] d;
        wr(2'd0, 32'h0107_0305);
        rd(2'd0, d); chk(d == 32'h0107_0305, "R9 ts readback", d, 32'h0107_0305);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(tag_ts == (raw_ts >> 3), "R2 tag shift", tag_ts, raw_ts >> 3);
            chk(xlat_ts == (raw_ts >> 7), "R2 xlat shift", xlat_ts, raw_ts >> 7);
            chk(log_ts == (raw_ts >> 5), "R3 log shifted", log_ts, raw_ts >> 5);
        end
        wr(2'd0, 32'h0100_0005);
        chk(tag_ts == raw_ts, "R2 zero shift", tag_ts, raw_ts);
        wr(2'd0, 32'h0000_0005);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            chk(log_ts == raw_ts / LDIV, "R3 legacy ms", log_ts, raw_ts / LDIV);
        end
    endtask

    task automatic t_div;
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h8000_0003);
        for (int idx = 0; idx < 12; idx++) begin
            chk(tick_o == ((idx % 4) == 3), "R4 tick spacing", tick_o, (idx % 4) == 3);
            chk(pulse_o[0] == ((idx % 4) == 3), "R7 period one", pulse_o[0], (idx % 4) == 3);
            @(negedge clk);
        end
    endtask

    task automatic t_gran;
        int first [NG];
        int cnt   [NG];
        logic [31:0] d;
        for (int g = 0; g < NG; g++) begin first[g] = -1; cnt[g] = 0; end
        wr(2'd1, 32'h39);
        rd(2'd1, d); chk(d == 32'h39, "R9 gran readback", d, 32'h39);
        wr(2'd2, 32'h8000_0001);
        for (int idx = 0; idx < 2100; idx++) begin
            for (int g = 0; g < NG; g++) begin
                if (pulse_o[g]) begin
                    cnt[g]++;
                    if (first[g] < 0) first[g] = idx;
                end
            end
            @(negedge clk);
        end
        chk(first[0] == 19, "R7 gen0 first", first[0], 19);
        chk(first[1] == 199, "R7 gen1 first", first[1], 199);
        chk(first[2] == 1999, "R7 gen2 first", first[2], 1999);
        chk(cnt[0] == 105, "R7 gen0 count", cnt[0], 105);
        chk(cnt[1] == 10, "R7 gen1 count", cnt[1], 10);
        chk(cnt[2] == 1, "R7 gen2 count", cnt[2], 1);
    endtask

    task automatic t_disable;
        wr(2'd2, 32'h0000_0001);
        for (int i = 0; i < 50; i++) begin
            chk(!tick_o && pulse_o == 0, "R5 disabled quiet", {tick_o, pulse_o}, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_collide;
        logic [31:0] d;
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h8000_0001);
        @(negedge clk);
        chk(tick_o == 1, "R4 first tick at V", tick_o, 1);
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'h8000_0002;
        #0.5;
        chk(tick_o == 1, "R6 tick kept in write cycle", tick_o, 1);
        chk(pulse_o[0] == 1, "R6 pulse kept in write cycle", pulse_o[0], 1);
        @(negedge clk);
        cfg_we = 1'b0;
        rd(2'd2, d); chk(d == 32'h8000_0002, "R9 div readback", d, 32'h8000_0002);
        for (int idx = 0; idx < 3; idx++) begin
            chk(tick_o == (idx == 2), "R6 restart phase", tick_o, idx == 2);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset;
        t_raw;
        t_shift;
        t_div;
        t_gran;
        t_disable;
        t_collide;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule